// File: doc/BRIEF.md
# Serial ASIC Control Bus Coordinator

This block is the host-side engine of a four-wire serial register bus that reaches one or more ASICs. The four wires are a serial clock, a command line, one active-low select per chip, and a response line. A local caller hands the engine one transaction at a time over a four-phase req/ack handshake. Each request carries a chip index, a write/read bit, a 30-bit word address and 32 bits of write data. The engine divides the system clock down to the serial clock and selects the addressed chip. It then shifts the command frame out and collects the chip's response frame.

The responding chip sends back the start bit, the operation bit and the word address before it sends any read data. The engine compares that echo with what it sent. A mismatch is reported on the fail flag, and so is a response that never starts. Read data and the fail flag are presented together with ack. Bus arbitration, the bridge to a register bus and the overall transaction timeout belong to the caller.

Top module: `sbc_coordinator`

## Requirements
- R1: A synchronous reset, whether it comes while idle or in the middle of a transaction, leaves every select high, the command line low, ack low and, in gated mode, the serial clock low.
- R2: The command frame is sent most significant bit first. It is a 1 start bit, then the operation bit (1 = write, 0 = read), then the 30-bit word address, then 32 bits of write data for a write only. After the frame the command line stays at 0.
- R3: The chip's response frame is expected as a 1 start bit, the echoed operation bit, the echoed 30-bit address and, for a read only, 32 data bits MSB first. If the echo matches, ack comes with fail = 0, and for a read the data is on rdata_o.
- R4: If the echoed operation bit or address differs from the value sent, the transaction ends with fail = 1.
- R5: If no response start bit is seen within RSP_TIMEOUT serial-clock rising edges after the command frame ends, the transaction ends with fail = 1 and rdata_o = 0.
- R6: During a transaction only the addressed chip's select is low. That select goes low before the first serial clock edge, and every select is high again when ack rises.
- R7: ack rises with rdata_o and fail_o valid. ack and both outputs stay unchanged while req_i stays high. ack falls after req_i drops, and no new transaction starts before then.
- R8: While asic_rst_n is low, no transaction starts: all selects stay high and ack stays low. A pending request proceeds once asic_rst_n is released.
- R9: The serial clock period is 2*HALF_DIV system clocks. The command line changes only on a falling serial clock edge, and the response is sampled on the rising edge. With FREE_RUN = 0 the serial clock is low whenever no transaction is in progress.
- R10: With RSP_SHARED = 0 each chip has its own response input, rsp_i[k] for chip k, and only the addressed chip's line is sampled. With RSP_SHARED = 1 a single shared line, rsp_i[0], is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| asic_rst_n | input | 1 | ASIC reset indication, low blocks new transactions |
| req_i | input | 1 | Transaction request, held until ack |
| chip_i | input | CHIP_W | Index of the target chip |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 30 | Word address |
| wdata_i | input | 32 | Write data |
| ack_o | output | 1 | Transaction complete, held until req_i drops |
| fail_o | output | 1 | Echo mismatch or missing response, valid with ack |
| rdata_o | output | 32 | Read data, valid with ack |
| sclk_o | output | 1 | Serial clock |
| cmd_o | output | 1 | Serial command line |
| sel_n_o | output | NUM_CHIPS | Active-low chip selects |
| rsp_i | input | RSP_SHARED ? 1 : NUM_CHIPS | Response line(s) |

## Verification
A behavioural chip model sits on each select. Every word of both chips is first written and then read back. The two chips hold different data patterns, so the readback shows whether the frame is decoded correctly and whether the response is taken from the addressed chip's line. Three fault patterns follow: a corrupted address echo on a write, the same on a read, and a silent chip. They separate the echo comparison from the timeout path. Further sequences hold asic_rst_n low with a pending request, reset the engine while it is shifting out a frame, and keep req_i high after ack. A monitor measures the serial clock period and watches for command changes while the serial clock is high.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  localparam int ADDR_W  = 30;
  localparam int DATA_W  = 32;
  localparam int CMD_MAX = 2 + ADDR_W + DATA_W;   // start + op + addr + data
  localparam int ECHO_W  = 1 + ADDR_W;            // op + addr after start
  localparam int RSP_MAX = ECHO_W + DATA_W;
  localparam int CNT_W   = $clog2(CMD_MAX + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEND, ST_WAIT, ST_RECV, ST_DONE
  } sbc_state_e;

  // number of command bits shifted out for a given operation
  function automatic logic [CNT_W-1:0] cmd_bits(input logic wr);
    return wr ? CNT_W'(CMD_MAX) : CNT_W'(CMD_MAX - DATA_W);
  endfunction

  // number of response bits collected after the start bit
  function automatic logic [CNT_W-1:0] rsp_bits(input logic wr);
    return wr ? CNT_W'(ECHO_W) : CNT_W'(RSP_MAX);
  endfunction

  // command frame left aligned, MSB goes out first
  function automatic logic [CMD_MAX-1:0] cmd_frame(input logic wr,
                                                   input logic [ADDR_W-1:0] addr,
                                                   input logic [DATA_W-1:0] wdata);
    return {1'b1, wr, addr, (wr ? wdata : {DATA_W{1'b0}})};
  endfunction

  // compare the echoed op and address with the ones sent
  function automatic logic echo_match(input logic wr,
                                      input logic [ADDR_W-1:0] addr,
                                      input logic [RSP_MAX-1:0] sr);
    logic [ECHO_W-1:0] echo;
    echo = wr ? sr[ECHO_W-1:0] : sr[RSP_MAX-1:DATA_W];
    return echo == {wr, addr};
  endfunction
endpackage

// File: rtl/sbc_clkgen.sv
module sbc_clkgen #(
  parameter int HALF_DIV = 4,
  parameter bit FREE_RUN = 1'b0,
  localparam int DIV_W = $clog2(HALF_DIV)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sclk_o,
  output logic rise_tick,
  output logic fall_tick
);
  logic [DIV_W-1:0] cnt;
  logic             sclk_q;
  logic             en;
  logic             tick;

  // keep running until a high phase has completed so no runt pulse appears
  always_comb begin
    en   = FREE_RUN || run || sclk_q;
    tick = en && (cnt == DIV_W'(HALF_DIV - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      sclk_q <= 1'b0;
    end else if (!en) begin
      cnt <= '0;
    end else if (tick) begin
      cnt    <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

  assign sclk_o    = sclk_q;
  assign rise_tick = tick && !sclk_q;
  assign fall_tick = tick && sclk_q;

  // R9: gated clock stays low while no transaction runs
  a_r9_gated_idle: assert property (@(posedge clk) disable iff (rst)
    (!FREE_RUN && !run && !sclk_q) |=> !sclk_q);
endmodule

// File: rtl/sbc_rsp_sel.sv
module sbc_rsp_sel #(
  parameter int NUM_CHIPS  = 2,
  parameter bit RSP_SHARED = 1'b0,
  parameter int CHIP_W     = 1,
  localparam int RSP_W = RSP_SHARED ? 1 : NUM_CHIPS
) (
  input  logic [RSP_W-1:0]  rsp_i,
  input  logic [CHIP_W-1:0] chip,
  output logic              rsp_bit
);
  generate
    if (RSP_SHARED) begin : g_shared
      logic [CHIP_W-1:0] chip_unused;
      assign chip_unused = chip;
      assign rsp_bit     = rsp_i[0];
    end else begin : g_per_chip
      assign rsp_bit = rsp_i[chip];
    end
  endgenerate
endmodule

// File: rtl/sbc_coordinator.sv
module sbc_coordinator
  import sbc_pkg::*;
#(
  parameter int NUM_CHIPS   = 2,
  parameter int HALF_DIV    = 4,
  parameter int RSP_TIMEOUT = 16,
  parameter bit FREE_RUN    = 1'b0,
  parameter bit RSP_SHARED  = 1'b0,
  localparam int CHIP_W = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1,
  localparam int RSP_W  = RSP_SHARED ? 1 : NUM_CHIPS,
  localparam int TO_W   = $clog2(RSP_TIMEOUT + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 asic_rst_n,
  input  logic                 req_i,
  input  logic [CHIP_W-1:0]    chip_i,
  input  logic                 wr_i,
  input  logic [29:0]          addr_i,
  input  logic [31:0]          wdata_i,
  output logic                 ack_o,
  output logic                 fail_o,
  output logic [31:0]          rdata_o,
  output logic                 sclk_o,
  output logic                 cmd_o,
  output logic [NUM_CHIPS-1:0] sel_n_o,
  input  logic [RSP_W-1:0]     rsp_i
);
  sbc_state_e           state;
  logic [CHIP_W-1:0]    chip_q;
  logic                 wr_q;
  logic [ADDR_W-1:0]    addr_q;
  logic [CMD_MAX-1:0]   cmd_sr;
  logic [CNT_W-1:0]     cmd_left;
  logic [CNT_W-1:0]     rsp_left;
  logic [RSP_MAX-1:0]   rsp_sr;
  logic [TO_W-1:0]      wait_cnt;
  logic                 cmd_q;
  logic                 fail_q;
  logic [DATA_W-1:0]    rdata_q;
  logic [NUM_CHIPS-1:0] sel_n_q;

  // named internal events
  logic                 run;
  logic                 rise_tick;
  logic                 fall_tick;
  logic                 rsp_bit;
  logic                 start_ev;
  logic                 timeout_ev;
  logic                 frame_end;
  logic                 echo_bad;
  logic [RSP_MAX-1:0]   nxt_sr;

  sbc_clkgen #(.HALF_DIV(HALF_DIV), .FREE_RUN(FREE_RUN)) u_clkgen (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .sclk_o    (sclk_o),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  sbc_rsp_sel #(.NUM_CHIPS(NUM_CHIPS), .RSP_SHARED(RSP_SHARED), .CHIP_W(CHIP_W)) u_rsp_sel (
    .rsp_i   (rsp_i),
    .chip    (chip_q),
    .rsp_bit (rsp_bit)
  );

  always_comb begin
    run        = (state == ST_SEND) || (state == ST_WAIT) || (state == ST_RECV);
    start_ev   = (state == ST_IDLE) && req_i && asic_rst_n;
    nxt_sr     = {rsp_sr[RSP_MAX-2:0], rsp_bit};
    timeout_ev = (state == ST_WAIT) && rise_tick && !rsp_bit &&
                 (wait_cnt == TO_W'(RSP_TIMEOUT - 1));
    frame_end  = (state == ST_RECV) && rise_tick && (rsp_left == CNT_W'(1));
    echo_bad   = !echo_match(wr_q, addr_q, nxt_sr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      chip_q   <= '0;
      wr_q     <= 1'b0;
      addr_q   <= '0;
      cmd_sr   <= '0;
      cmd_left <= '0;
      rsp_left <= '0;
      rsp_sr   <= '0;
      wait_cnt <= '0;
      cmd_q    <= 1'b0;
      fail_q   <= 1'b0;
      rdata_q  <= '0;
      sel_n_q  <= '1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_ev) begin
            chip_q   <= chip_i;
            wr_q     <= wr_i;
            addr_q   <= addr_i;
            cmd_sr   <= cmd_frame(wr_i, addr_i, wdata_i);
            cmd_left <= cmd_bits(wr_i);
            rsp_sr   <= '0;
            wait_cnt <= '0;
            fail_q   <= 1'b0;
            rdata_q  <= '0;
            sel_n_q  <= ~(NUM_CHIPS'(1) << chip_i);
            state    <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (fall_tick) begin
            if (cmd_left != '0) begin
              cmd_q    <= cmd_sr[CMD_MAX-1];
              cmd_sr   <= cmd_sr << 1;
              cmd_left <= cmd_left - CNT_W'(1);
            end else begin
              cmd_q <= 1'b0;
              state <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (rise_tick) begin
            if (rsp_bit) begin
              rsp_left <= rsp_bits(wr_q);
              state    <= ST_RECV;
            end else if (timeout_ev) begin
              fail_q  <= 1'b1;
              sel_n_q <= '1;
              state   <= ST_DONE;
            end else begin
              wait_cnt <= wait_cnt + TO_W'(1);
            end
          end
        end
        ST_RECV: begin
          if (rise_tick) begin
            rsp_sr   <= nxt_sr;
            rsp_left <= rsp_left - CNT_W'(1);
            if (frame_end) begin
              fail_q  <= echo_bad;
              rdata_q <= wr_q ? '0 : nxt_sr[DATA_W-1:0];
              sel_n_q <= '1;
              state   <= ST_DONE;
            end
          end
        end
        ST_DONE: begin
          if (!req_i) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ack_o   = (state == ST_DONE);
  assign fail_o  = fail_q;
  assign rdata_o = rdata_q;
  assign cmd_o   = cmd_q;
  assign sel_n_o = sel_n_q;

  // R6: never more than one chip selected
  a_r6_one_select: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~sel_n_o));
  // R6: every select released when ack is given
  a_r6_release_at_ack: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> (&sel_n_o));
  // R7: ack held while the request is held
  a_r7_ack_held: assert property (@(posedge clk) disable iff (rst)
    (ack_o && req_i) |=> (ack_o && $stable(rdata_o) && $stable(fail_o)));
  // R8: no start while the ASIC reset is held
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_IDLE) && !asic_rst_n) |=> (&sel_n_o));
  // R9: command line moves only on a falling serial clock edge
  a_r9_cmd_on_fall: assert property (@(posedge clk) disable iff (rst)
    !fall_tick |=> $stable(cmd_o));
  // R2: command line is low outside a transaction
  a_r2_cmd_low_idle: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !cmd_o);
  // R5: start-bit wait never exceeds its bound
  a_r5_wait_bound: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT) |-> (wait_cnt < TO_W'(RSP_TIMEOUT)));
endmodule

// File: tb/tb_sbc_coordinator.sv
module tb_sbc_chip (
  input  logic sclk,
  input  logic sel_n,
  input  logic cmd,
  input  logic mute,
  input  logic corrupt,
  output logic rsp
);
  logic [63:0] rx_sr = '0;
  logic [63:0] tx_sr = '0;
  logic [63:0] nxt   = '0;
  logic [29:0] a     = '0;
  int          rx_n  = 0;
  int          tx_n  = 0;
  bit          rx_on = 1'b0;
  bit          op_w  = 1'b0;
  logic        rsp_q = 1'b0;
  logic [31:0] mem [8];

  assign rsp = rsp_q;

  always @(posedge sclk or negedge sclk or posedge sel_n) begin
    if (sel_n) begin
      rx_on <= 1'b0;
      rx_n  <= 0;
      tx_n  <= 0;
      rsp_q <= 1'b0;
    end else if (sclk) begin
      if (!rx_on && tx_n == 0) begin
        if (cmd) begin
          rx_on <= 1'b1;
          rx_sr <= 64'd1;
          rx_n  <= 1;
        end
      end else if (rx_on) begin
        nxt = {rx_sr[62:0], cmd};
        rx_sr <= nxt;
        rx_n  <= rx_n + 1;
        if (rx_n == 1) op_w <= cmd;
        if (rx_n >= 2 && (rx_n + 1) == (op_w ? 64 : 32)) begin
          rx_on <= 1'b0;
          if (op_w) begin
            a = nxt[61:32];
            mem[a[2:0]] <= nxt[31:0];
            tx_sr <= {1'b1, 1'b1, a ^ 30'(corrupt), 32'h0};
          end else begin
            a = nxt[29:0];
            tx_sr <= {1'b1, 1'b0, a ^ 30'(corrupt), mem[a[2:0]]};
          end
          tx_n <= mute ? 0 : (op_w ? 32 : 64);
        end
      end
    end else begin
      if (tx_n > 0) begin
        rsp_q <= tx_sr[63];
        tx_sr <= tx_sr << 1;
        tx_n  <= tx_n - 1;
      end else begin
        rsp_q <= 1'b0;
      end
    end
  end
endmodule

module tb_sbc_coordinator;
  localparam int HALF    = 2;
  localparam int TMO     = 16;
  localparam int WD_LIM  = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        asic_rst_n = 1'b1;
  logic        req_i = 1'b0;
  logic [0:0]  chip_i = '0;
  logic        wr_i = 1'b0;
  logic [29:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        ack_o, fail_o, sclk_o, cmd_o;
  logic [31:0] rdata_o;
  logic [1:0]  sel_n_o;
  logic [1:0]  rsp;
  logic [1:0]  mute = '0;
  logic [1:0]  corrupt = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit wd_hit = 1'b0;
  int last_rise = -1;
  int per_min = 1000;
  int per_max = 0;
  int cmd_bad = 0;
  logic sclk_d = 1'b0;
  logic cmd_d  = 1'b0;

  always #5 clk = ~clk;

  sbc_coordinator #(.NUM_CHIPS(2), .HALF_DIV(HALF), .RSP_TIMEOUT(TMO),
                    .FREE_RUN(1'b0), .RSP_SHARED(1'b0)) dut (
    .clk(clk), .rst(rst), .asic_rst_n(asic_rst_n), .req_i(req_i),
    .chip_i(chip_i), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .ack_o(ack_o), .fail_o(fail_o), .rdata_o(rdata_o), .sclk_o(sclk_o),
    .cmd_o(cmd_o), .sel_n_o(sel_n_o), .rsp_i(rsp)
  );

  tb_sbc_chip u_chip0 (.sclk(sclk_o), .sel_n(sel_n_o[0]), .cmd(cmd_o),
                       .mute(mute[0]), .corrupt(corrupt[0]), .rsp(rsp[0]));
  tb_sbc_chip u_chip1 (.sclk(sclk_o), .sel_n(sel_n_o[1]), .cmd(cmd_o),
                       .mute(mute[1]), .corrupt(corrupt[1]), .rsp(rsp[1]));

  // watchdog plus serial clock monitor
  always @(negedge clk) begin
    int per;
    cyc++;
    if (cyc > WD_LIM) wd_hit = 1'b1;
    if (sclk_o && !sclk_d) begin
      if (last_rise >= 0) begin
        per = cyc - last_rise;
        if (per < per_min) per_min = per;
        if (per > per_max) per_max = per;
      end
      last_rise = cyc;
    end
    if (&sel_n_o) last_rise = -1;
    if (cmd_o != cmd_d && sclk_o) cmd_bad++;
    sclk_d = sclk_o;
    cmd_d  = cmd_o;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [29:0] addr_of(input int idx);
    return (30'h15A5A5A0 ^ (30'(idx) << 24)) | 30'(idx);
  endfunction

  function automatic logic [31:0] data_of(input int ch, input int idx);
    return 32'(32'h9E3779B9 * (ch * 8 + idx + 1));
  endfunction

  task automatic xfer(input int ch, input bit wr, input logic [29:0] a,
                      input logic [31:0] wd, output logic [31:0] rd, output bit fl);
    bit wrong_sel = 1'b0;
    logic [1:0] sel_exp = ~(2'b01 << ch);
    @(negedge clk);
    chip_i = 1'(ch); wr_i = wr; addr_i = a; wdata_i = wd; req_i = 1'b1;
    do begin
      @(negedge clk);
      if (sel_n_o != 2'b11 && sel_n_o != sel_exp) wrong_sel = 1'b1;
    end while (!ack_o && !wd_hit);
    rd = rdata_o;
    fl = fail_o;
    chk(!wrong_sel, "R6 only addressed select low", 64'(wrong_sel), 64'd0);
    chk(sel_n_o == 2'b11, "R6 selects released at ack", 64'(sel_n_o), 64'h3);
    chk(cmd_o == 1'b0, "R2 command low after frame", 64'(cmd_o), 64'd0);
    repeat (3) @(negedge clk);
    chk(ack_o && rdata_o == rd && fail_o == fl, "R7 ack and results held",
        {31'd0, ack_o, rdata_o}, {31'd1, rd});
    req_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(!ack_o, "R7 ack drops after req", 64'(ack_o), 64'd0);
  endtask

  initial begin
    logic [31:0] rd;
    bit fl;
    bit blocked;

    // R1: reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sel_n_o == 2'b11 && !cmd_o && !ack_o && !sclk_o, "R1 reset state",
        {60'd0, sel_n_o, cmd_o, ack_o}, 64'hC);

    // R2 R3 R10: write every word of both chips, interleaved
    for (int i = 0; i < 8; i++) begin
      for (int c = 0; c < 2; c++) begin
        xfer(c, 1'b1, addr_of(i), data_of(c, i), rd, fl);
        chk(!fl, "R3 write echo accepted", 64'(fl), 64'd0);
      end
    end
    // R3 R10: read back, each chip distinct data
    for (int i = 7; i >= 0; i--) begin
      for (int c = 1; c >= 0; c--) begin
        xfer(c, 1'b0, addr_of(i), 32'hFFFF_FFFF, rd, fl);
        chk(!fl, "R3 read echo accepted", 64'(fl), 64'd0);
        chk(rd == data_of(c, i), "R10 R3 read data from addressed chip",
            64'(rd), 64'(data_of(c, i)));
      end
    end

    // R9: serial clock period and edge discipline
    chk(per_min == 2 * HALF && per_max == 2 * HALF, "R9 serial clock period",
        64'(per_max), 64'(2 * HALF));
    chk(cmd_bad == 0, "R9 command changes only while serial clock low",
        64'(cmd_bad), 64'd0);
    blocked = 1'b0;
    repeat (40) begin
      @(negedge clk);
      if (sclk_o) blocked = 1'b1;
    end
    chk(!blocked, "R9 gated serial clock low when idle", 64'(blocked), 64'd0);

    // R4: corrupted echo on write and read
    corrupt = 2'b10;
    xfer(1, 1'b1, addr_of(3), 32'h1234_5678, rd, fl);
    chk(fl, "R4 write echo mismatch flags fail", 64'(fl), 64'd1);
    xfer(1, 1'b0, addr_of(3), 32'h0, rd, fl);
    chk(fl, "R4 read echo mismatch flags fail", 64'(fl), 64'd1);
    corrupt = 2'b00;
    xfer(0, 1'b0, addr_of(3), 32'h0, rd, fl);
    chk(!fl && rd == data_of(0, 3), "R4 clean echo after fault passes",
        {31'd0, fl, rd}, {32'd0, data_of(0, 3)});

    // R5: silent chip times out
    mute = 2'b01;
    xfer(0, 1'b0, addr_of(5), 32'h0, rd, fl);
    chk(fl && rd == 32'h0, "R5 missing response flags fail",
        {31'd0, fl, rd}, {31'd0, 1'b1, 32'h0});
    xfer(0, 1'b1, addr_of(5), 32'hAAAA_5555, rd, fl);
    chk(fl, "R5 missing write echo flags fail", 64'(fl), 64'd1);
    mute = 2'b00;

    // R8: ASIC reset holds off a pending request
    asic_rst_n = 1'b0;
    @(negedge clk);
    chip_i = 1'b1; wr_i = 1'b1; addr_i = addr_of(6); wdata_i = 32'h0BAD_F00D;
    req_i = 1'b1;
    blocked = 1'b1;
    repeat (100) begin
      @(negedge clk);
      if (sel_n_o != 2'b11 || ack_o) blocked = 1'b0;
    end
    chk(blocked, "R8 no transaction while ASIC reset low", 64'(blocked), 64'd1);
    asic_rst_n = 1'b1;
    while (!ack_o && !wd_hit) @(negedge clk);
    chk(!fail_o, "R8 pending request runs after release", 64'(fail_o), 64'd0);
    req_i = 1'b0;
    repeat (2) @(negedge clk);
    xfer(1, 1'b0, addr_of(6), 32'h0, rd, fl);
    chk(rd == 32'h0BAD_F00D, "R8 released write landed", 64'(rd), 64'h0BADF00D);

    // R1: reset in the middle of a transaction
    @(negedge clk);
    chip_i = 1'b0; wr_i = 1'b1; addr_i = addr_of(2); wdata_i = 32'hFFFF_FFFF;
    req_i = 1'b1;
    repeat (40) @(negedge clk);
    rst = 1'b1;
    req_i = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sel_n_o == 2'b11 && !cmd_o && !ack_o && !sclk_o, "R1 reset mid transaction",
        {60'd0, sel_n_o, cmd_o, ack_o}, 64'hC);
    xfer(0, 1'b0, addr_of(2), 32'h0, rd, fl);
    chk(!fl && rd == data_of(0, 2), "R1 engine usable after reset",
        {31'd0, fl, rd}, {32'd0, data_of(0, 2)});

    if (wd_hit) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog expired actual=%0d expected<%0d", cyc, WD_LIM);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule